// File: doc/BRIEF.md
# Interlaken Metaframe Generator

This block assembles the framing-layer metaframes of a single Interlaken lane. It pulls 64-bit payload words from a transmit buffer over a valid/ready interface. Around the payload it places fixed-position control words: a synchronization word, a scrambler-state word and a diagnostic word. Every slot that does not carry payload is filled with a skip word. Each output word carries a control/data flag, and a single-cycle pulse marks the first word of every metaframe. Scrambling, CRC-32 computation, disparity encoding and serialization belong to neighbouring blocks. The scrambler state and the CRC value arrive here on inputs.

The metaframe length is set at runtime. The burst-enable and lane-status inputs are captured once, on the clock edge that launches the synchronization word. That edge lies inside the window in which both inputs must be held stable. With burst disabled the generator leaves the buffer untouched and sends skip words for the whole frame. With burst enabled it reads a word in every payload slot, and it falls back to a skip word whenever the buffer has nothing to offer. A low generator enable idles the output and rewinds the frame position.

Top module: `metaframeGen`

## Requirements
- R1: While reset is held, and after it is released with the generator disabled, outValid, outCtrl, framePulse and pldReady are 0 and outData is all zeros.
- R2: With an effective length L, slot 0 carries the synchronization word 64'h78F678F678F678F6. Slot 1 carries the scrambler-state word {6'b001010, scrState}. Slot L-1 carries the diagnostic word. All three have outCtrl=1. Slots 2 to L-2 are payload slots.
- R3: framePulse is high for exactly one cycle, together with each synchronization word, and at no other time.
- R4: frameLen is sampled at the start of each metaframe. Values below 4 are treated as 4 and values above 8192 are treated as 8192. The next synchronization word follows immediately after slot L-1.
- R5: burstEnable and laneStatus are sampled only on the edge that launches the synchronization word. Changes later in the frame have no effect on that frame.
- R6: With burst captured as 0, pldReady stays low for the whole frame. Every payload slot then carries the skip word {6'b000111, 2'b00, 56'h1E1E1E1E1E1E1E} with outCtrl=1.
- R7: With burst captured as 1, pldReady is high in every payload slot and low in the control-word slots. A word accepted with pldValid and pldReady high appears on outData in the next cycle, with outCtrl=0.
- R8: If pldValid is low in a payload slot while burst is captured as 1, that slot carries the skip word and no buffer word is consumed. The next accepted word is the one still waiting in the buffer.
- R9: The diagnostic word holds 6'b011001 in bits [63:58] and zeros in [57:34]. Bits [33:32] hold the lane status captured at the start of the same frame. Bits [31:0] hold the crcValue present on the edge that produces the diagnostic slot.
- R10: When genEnable is low, pldReady is 0, and from the next cycle on outValid and framePulse are 0. When genEnable is raised again, the next output word is a synchronization word with framePulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| genEnable | input | 1 | Generator enable; low idles output and rewinds position |
| frameLen | input | LEN_W | Metaframe length in words |
| burstEnable | input | 1 | Read payload this frame (1) or fill with skip words (0) |
| laneStatus | input | 2 | Lane status for the diagnostic word |
| scrState | input | 58 | Scrambler state placed in the scrambler-state word |
| crcValue | input | 32 | CRC placed in the diagnostic word |
| pldData | input | 64 | Payload word from the transmit buffer |
| pldValid | input | 1 | Buffer holds a word |
| pldReady | output | 1 | Generator takes the word this cycle |
| outData | output | 64 | Output word |
| outCtrl | output | 1 | 1 for a control word, 0 for payload |
| outValid | output | 1 | Output word present |
| framePulse | output | 1 | First word of a metaframe |

## Verification
Frames are run at lengths below the minimum, at the minimum, at the maximum clamp and in between. Each length is combined with burst on or off and with a buffer that is always ready, never ready or missing every third word. Burst off against an always-ready buffer separates the frame-wide skip fill from the empty-slot fallback. The gapped buffer shows that an empty slot consumes no word, because the next payload value must carry on the running sequence. Inverting burst and status in the middle of each frame exposes any sampling outside the frame boundary, and dropping the enable mid-frame checks the idle state and the restart at the synchronization word.

// File: rtl/mfgPkg.sv
package mfgPkg;
  localparam int WORD_W = 64;
  localparam int SCR_W  = 58;
  localparam int CRC_W  = 32;

  localparam logic [WORD_W-1:0] SYNC_WORD = 64'h78F6_78F6_78F6_78F6;
  localparam logic [5:0] SCRAM_TYPE = 6'b001010;
  localparam logic [5:0] SKIP_TYPE  = 6'b000111;
  localparam logic [5:0] DIAG_TYPE  = 6'b011001;
  localparam logic [WORD_W-1:0] SKIP_WORD = {SKIP_TYPE, 2'b00, 56'h1E1E1E1E1E1E1E};

  typedef enum logic [2:0] {
    SLOT_IDLE,
    SLOT_SYNC,
    SLOT_SCRAM,
    SLOT_DATA,
    SLOT_SKIP,
    SLOT_DIAG
  } slotKind_e;

  typedef struct packed {
    slotKind_e  kind;
    logic       startFrame;
    logic [1:0] status;
  } genStrobe_t;
endpackage

// File: rtl/mfgControl.sv
module mfgControl
  import mfgPkg::*;
#(
  parameter int LEN_W   = 14,
  parameter int MAX_LEN = 8192,
  parameter int MIN_LEN = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             genEnable,
  input  logic [LEN_W-1:0] frameLen,
  input  logic             burstEnable,
  input  logic [1:0]       laneStatus,
  input  logic             pldValid,
  output logic             pldReady,
  output genStrobe_t       strobe
);
  localparam logic [LEN_W-1:0] MaxLen = LEN_W'(MAX_LEN);
  localparam logic [LEN_W-1:0] MinLen = LEN_W'(MIN_LEN);

  logic [LEN_W-1:0] pos;
  logic [LEN_W-1:0] lenLat;
  logic [LEN_W-1:0] clampLen;
  logic             burstLat;
  logic [1:0]       statusLat;
  logic             atStart;
  logic             atScram;
  logic             atLast;
  logic             inBody;

  always_comb begin
    if (frameLen < MinLen)      clampLen = MinLen;
    else if (frameLen > MaxLen) clampLen = MaxLen;
    else                        clampLen = frameLen;
  end

  // Slot decode; the minimum length keeps slots 0 and 1 clear of the last slot.
  assign atStart = (pos == '0);
  assign atScram = (pos == LEN_W'(1));
  assign atLast  = !atStart && (pos == lenLat - 1'b1);
  assign inBody  = !atStart && !atScram && !atLast;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos       <= '0;
      lenLat    <= MinLen;
      burstLat  <= 1'b0;
      statusLat <= 2'b00;
    end else if (!genEnable) begin
      pos <= '0;
    end else begin
      if (atStart) begin
        // Frame boundary: the only point where the per-frame controls are taken.
        lenLat    <= clampLen;
        burstLat  <= burstEnable;
        statusLat <= laneStatus;
      end
      pos <= atLast ? '0 : pos + 1'b1;
    end
  end

  assign pldReady = genEnable && inBody && burstLat;

  always_comb begin
    strobe.startFrame = genEnable && atStart;
    strobe.status     = statusLat;
    if (!genEnable)                 strobe.kind = SLOT_IDLE;
    else if (atStart)               strobe.kind = SLOT_SYNC;
    else if (atScram)               strobe.kind = SLOT_SCRAM;
    else if (atLast)                strobe.kind = SLOT_DIAG;
    else if (burstLat && pldValid)  strobe.kind = SLOT_DATA;
    else                            strobe.kind = SLOT_SKIP;
  end
endmodule

// File: rtl/mfgDatapath.sv
module mfgDatapath
  import mfgPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  genStrobe_t        strobe,
  input  logic [WORD_W-1:0] pldData,
  input  logic [SCR_W-1:0]  scrState,
  input  logic [CRC_W-1:0]  crcValue,
  output logic [WORD_W-1:0] outData,
  output logic              outCtrl,
  output logic              outValid,
  output logic              framePulse
);
  logic [WORD_W-1:0] nextWord;
  logic              nextCtrl;

  always_comb begin
    nextCtrl = 1'b1;
    unique case (strobe.kind)
      SLOT_SYNC:  nextWord = SYNC_WORD;
      SLOT_SCRAM: nextWord = {SCRAM_TYPE, scrState};
      SLOT_DIAG:  nextWord = {DIAG_TYPE, 24'h0, strobe.status, crcValue};
      SLOT_DATA: begin
        nextWord = pldData;
        nextCtrl = 1'b0;
      end
      SLOT_SKIP:  nextWord = SKIP_WORD;
      default: begin
        nextWord = '0;
        nextCtrl = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData    <= '0;
      outCtrl    <= 1'b0;
      outValid   <= 1'b0;
      framePulse <= 1'b0;
    end else begin
      outData    <= nextWord;
      outCtrl    <= nextCtrl;
      outValid   <= (strobe.kind != SLOT_IDLE);
      framePulse <= strobe.startFrame;
    end
  end
endmodule

// File: rtl/metaframeGen.sv
module metaframeGen
  import mfgPkg::*;
#(
  parameter int LEN_W   = 14,
  parameter int MAX_LEN = 8192,
  parameter int MIN_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              genEnable,
  input  logic [LEN_W-1:0]  frameLen,
  input  logic              burstEnable,
  input  logic [1:0]        laneStatus,
  input  logic [SCR_W-1:0]  scrState,
  input  logic [CRC_W-1:0]  crcValue,
  input  logic [WORD_W-1:0] pldData,
  input  logic              pldValid,
  output logic              pldReady,
  output logic [WORD_W-1:0] outData,
  output logic              outCtrl,
  output logic              outValid,
  output logic              framePulse
);
  genStrobe_t strobe;

  mfgControl #(
    .LEN_W  (LEN_W),
    .MAX_LEN(MAX_LEN),
    .MIN_LEN(MIN_LEN)
  ) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .genEnable  (genEnable),
    .frameLen   (frameLen),
    .burstEnable(burstEnable),
    .laneStatus (laneStatus),
    .pldValid   (pldValid),
    .pldReady   (pldReady),
    .strobe     (strobe)
  );

  mfgDatapath u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .pldData   (pldData),
    .scrState  (scrState),
    .crcValue  (crcValue),
    .outData   (outData),
    .outCtrl   (outCtrl),
    .outValid  (outValid),
    .framePulse(framePulse)
  );
endmodule

// File: rtl/mfgChecker.sv
module mfgChecker
  import mfgPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              genEnable,
  input logic [WORD_W-1:0] pldData,
  input logic              pldValid,
  input logic              pldReady,
  input logic [WORD_W-1:0] outData,
  input logic              outCtrl,
  input logic              outValid,
  input logic              framePulse
);
  p_pulse_with_sync_r3: assert property (@(posedge clk) disable iff (!rstN)
    framePulse |-> (outValid && outCtrl && outData == SYNC_WORD));

  p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    framePulse |=> !framePulse);

  p_idle_after_disable_r10: assert property (@(posedge clk) disable iff (!rstN)
    !genEnable |=> (!outValid && !framePulse));

  p_no_ready_disabled_r10: assert property (@(posedge clk) disable iff (!rstN)
    !genEnable |-> !pldReady);

  p_no_read_in_scram_slot_r7: assert property (@(posedge clk) disable iff (!rstN)
    framePulse |-> !pldReady);

  p_payload_passes_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pldValid && pldReady) |=> (outValid && !outCtrl && outData == $past(pldData)));

  p_quiet_when_invalid_r1: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!outCtrl && !framePulse));
endmodule

bind metaframeGen mfgChecker u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .genEnable (genEnable),
  .pldData   (pldData),
  .pldValid  (pldValid),
  .pldReady  (pldReady),
  .outData   (outData),
  .outCtrl   (outCtrl),
  .outValid  (outValid),
  .framePulse(framePulse)
);

// File: tb/tb_metaframeGen.sv
module tb_metaframeGen;
  localparam int PERIOD = 10;
  localparam int LEN_W  = 14;

  localparam logic [63:0] SYNC_W = 64'h78F678F678F678F6;
  localparam logic [63:0] SKIP_W = {6'b000111, 2'b00, 56'h1E1E1E1E1E1E1E};

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             burst;
    logic [1:0]       status;
    logic [1:0]       vpat;   // 0 always valid, 1 gap every third slot, 2 never valid
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{14'd6,     1'b1, 2'd2, 2'd0},
    '{14'd4,     1'b1, 2'd1, 2'd0},
    '{14'd2,     1'b1, 2'd3, 2'd0},
    '{14'd9,     1'b0, 2'd0, 2'd0},
    '{14'd10,    1'b1, 2'd2, 2'd1},
    '{14'd7,     1'b1, 2'd1, 2'd2},
    '{14'd20,    1'b0, 2'd3, 2'd1},
    '{14'd33,    1'b1, 2'd0, 2'd1},
    '{14'h3FFF,  1'b1, 2'd2, 2'd1}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              genEnable = 1'b0;
  logic [LEN_W-1:0]  frameLen = '0;
  logic              burstEnable = 1'b0;
  logic [1:0]        laneStatus = 2'b00;
  logic [57:0]       scrState = '0;
  logic [31:0]       crcValue = '0;
  logic [63:0]       pldData = '0;
  logic              pldValid = 1'b0;
  logic              pldReady;
  logic [63:0]       outData;
  logic              outCtrl;
  logic              outValid;
  logic              framePulse;

  int checks = 0;
  int fails  = 0;
  logic [63:0] nextWord = 64'h1000_0000_0000_0001;

  always #(PERIOD/2) clk = ~clk;

  metaframeGen #(.LEN_W(LEN_W)) dut (
    .clk(clk), .rstN(rstN), .genEnable(genEnable), .frameLen(frameLen),
    .burstEnable(burstEnable), .laneStatus(laneStatus), .scrState(scrState),
    .crcValue(crcValue), .pldData(pldData), .pldValid(pldValid),
    .pldReady(pldReady), .outData(outData), .outCtrl(outCtrl),
    .outValid(outValid), .framePulse(framePulse)
  );

  task automatic check(input string req, input logic [66:0] act, input logic [66:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int effLen(input logic [LEN_W-1:0] l);
    if (l < 4) return 4;
    if (l > 8192) return 8192;
    return int'(l);
  endfunction

  function automatic logic vOf(input logic [1:0] p, input int k);
    if (p == 2'd0) return 1'b1;
    if (p == 2'd1) return (k % 3) != 0;
    return 1'b0;
  endfunction

  task automatic runVec(input int idx);
    vec_t v;
    int   eff;
    logic vk;
    logic [66:0] exp;
    v = VECS[idx];
    eff = effLen(v.len);
    @(negedge clk);
    genEnable = 1'b0;
    @(negedge clk);
    frameLen    = v.len;
    burstEnable = v.burst;
    laneStatus  = v.status;
    crcValue    = 32'hC0DE_0000 + 32'(idx);
    scrState    = {2'b01, 24'hABCDEF, 32'(idx)};
    genEnable   = 1'b1;
    for (int k = 0; k <= eff; k++) begin
      vk = vOf(v.vpat, k);
      pldValid = vk;
      pldData  = nextWord;
      #1;
      // R6/R7 ready only in payload slots of a burst frame
      check(v.burst ? "R7 ready" : "R6 ready", {66'h0, pldReady},
            {66'h0, (v.burst && k >= 2 && k <= eff - 2)});
      if (k == 2) begin
        // R5 mid-frame changes must not affect this frame
        burstEnable = ~v.burst;
        laneStatus  = ~v.status;
      end
      @(posedge clk);
      @(negedge clk);
      if (k == 0 || k == eff)
        exp = {1'b1, 1'b1, 1'b1, SYNC_W};
      else if (k == 1)
        exp = {1'b1, 1'b1, 1'b0, 6'b001010, scrState};
      else if (k == eff - 1)
        exp = {1'b1, 1'b1, 1'b0, 6'b011001, 24'h0, v.status, crcValue};
      else if (v.burst && vk) begin
        exp = {1'b1, 1'b0, 1'b0, nextWord};
        nextWord = nextWord + 64'h3;
      end else
        exp = {1'b1, 1'b1, 1'b0, SKIP_W};
      if (k == 0 || k == eff) check("R3 R4 sync slot", {outValid, outCtrl, framePulse, outData}, exp);
      else if (k == 1) check("R2 scram slot", {outValid, outCtrl, framePulse, outData}, exp);
      else if (k == eff - 1) check("R9 R5 diag slot", {outValid, outCtrl, framePulse, outData}, exp);
      else if (v.burst) check("R7 R8 payload slot", {outValid, outCtrl, framePulse, outData}, exp);
      else check("R6 skip slot", {outValid, outCtrl, framePulse, outData}, exp);
    end
    burstEnable = v.burst;
    laneStatus  = v.status;
    pldValid    = 1'b0;
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset", {pldReady, outValid, outCtrl, framePulse, outData}, 68'h0);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 after reset", {pldReady, outValid, outCtrl, framePulse, outData}, 68'h0);

    for (int i = 0; i < NVEC; i++) runVec(i);

    // R10 enable dropped mid-frame, then restart at sync
    @(negedge clk);
    genEnable = 1'b0;
    @(negedge clk);
    frameLen = 14'd8; burstEnable = 1'b1; pldValid = 1'b1; genEnable = 1'b1;
    repeat (4) @(negedge clk);
    genEnable = 1'b0;
    #1;
    check("R10 ready when off", {66'h0, pldReady}, 67'h0);
    @(negedge clk);
    check("R10 idle", {outValid, framePulse}, 2'b00);
    @(negedge clk);
    check("R10 idle hold", {outValid, framePulse}, 2'b00);
    genEnable = 1'b1;
    @(negedge clk);
    check("R10 restart", {outValid, outCtrl, framePulse, outData}, {3'b111, SYNC_W});
    @(negedge clk);
    check("R3 pulse single", {66'h0, framePulse}, 67'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule